// File: doc/BRIEF.md
# Bi-Endian Load/Store Byte Lane Unit

This block sits between a 32-bit register datapath and a byte-addressable memory port. Memory words are read and written as four byte lanes. A multi-byte value is named by the lowest byte address it covers. On a store, the unit places the register bytes onto the proper lanes and raises one byte enable per lane written. On a load, it picks the addressed bytes out of the returned word, puts them back into register order and widens the result to 32 bits by zero or sign extension.

A run-time mode input selects the byte order. In big-endian order the most significant byte sits at the lowest address. In little-endian order the least significant byte sits there. Every access must be naturally aligned. An access that breaks this rule never reaches memory and is reported on a fault output instead. The datapath only ever does arithmetic on full 32-bit words, so the narrow sizes exist only as transfer sizes here.

Timing is one request and one response. A request is sampled on a clock edge, and the memory-side outputs are registered on that edge. Memory answers a read within the same response cycle, and the load result is formed from that answer without any further register.

Top module: `bi_endian_lane_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, mem_req, mem_we, mem_be, mem_wdata, mem_addr, fault, load_valid and load_data are all zero.
- R2: A big-endian word store of 0xAABBCCDD to an aligned address writes 0xAA, 0xBB, 0xCC, 0xDD to that address and the next three, in that order. Narrow stores put their most significant byte at the lowest address.
- R3: A little-endian word store of 0xAABBCCDD writes 0xDD, 0xCC, 0xBB, 0xAA in ascending address order. Narrow stores put their least significant byte at the lowest address.
- R4: req_size encodes 00 byte, 01 halfword, 10 word and 11 invalid. Byte lane i is mem_wdata/mem_rdata bits 8i+7..8i and holds the byte at mem_addr+i. mem_addr is the request address with its low two bits cleared. mem_be has ones on exactly the 1, 2 or 4 lanes starting at lane req_addr[1:0].
- R5: A big-endian load returns the byte at the lowest address as the most significant byte of the loaded value.
- R6: A little-endian load returns the byte at the lowest address as the least significant byte of the loaded value.
- R7: Byte and halfword loads copy the top bit of the loaded value into all upper bits when req_sext is 1, and fill the upper bits with zeros when it is 0. Word loads ignore req_sext.
- R8: A halfword at an odd address, a word at an address that is not a multiple of 4, or size code 11 raises fault for exactly one cycle. In that cycle mem_req, mem_we and every mem_be bit stay low, so memory is left unchanged.
- R9: A faulted load gives load_valid 0 and load_data 0. load_data is zero whenever load_valid is low.
- R10: The response to a request sampled at a clock edge appears right after that edge, with exactly one of mem_req and fault high. load_valid and load_data are valid in that same cycle, computed from mem_rdata. With no request, the next cycle has mem_req, fault and load_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 store, 0 load |
| req_size | input | 2 | Access size code |
| req_sext | input | 1 | Sign-extend narrow loads |
| big_endian | input | 1 | Byte order mode: 1 big, 0 little |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | DATA_W | Store value, right-justified |
| mem_req | output | 1 | Memory access issued |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | DATA_W/8 | Per-lane byte enables |
| mem_wdata | output | DATA_W | Lane-positioned store data |
| mem_rdata | input | DATA_W | Word returned by memory in the response cycle |
| load_valid | output | 1 | Load result valid |
| load_data | output | DATA_W | Ordered and extended load result |
| fault | output | 1 | Misaligned or invalid-size access |

## Verification
The assertions expect req_valid, req_write, req_size and req_addr to have known values on every sampled edge once reset has been released. They also expect the bench memory to drive mem_rdata as a function of mem_addr alone. The bench changes inputs only a short time after a rising edge, and it holds req_valid low between scenarios. The memory model applies writes on the falling edge, while the write strobe is steady. Every request uses one of the four size codes, including the invalid one, so each timing and fault property is exercised under its stated conditions.

// File: rtl/lane_unit_pkg.sv
package lane_unit_pkg;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'b00,
        ACC_HALF = 2'b01,
        ACC_WORD = 2'b10,
        ACC_BAD  = 2'b11
    } acc_size_e;

    // number of bytes moved by an access; zero for the invalid code
    function automatic int size_bytes(acc_size_e s);
        case (s)
            ACC_BYTE: return 1;
            ACC_HALF: return 2;
            ACC_WORD: return 4;
            default:  return 0;
        endcase
    endfunction

    // context of a load carried from the request edge into the response cycle
    typedef struct packed {
        acc_size_e  size;
        logic [1:0] off;
        logic       sext;
        logic       big;
        logic       live;
    } load_ctx_t;

endpackage

// File: rtl/lane_align_check.sv
module lane_align_check
    import lane_unit_pkg::*;
(
    input  acc_size_e  size,
    input  logic [1:0] off,
    output logic       misaligned
);
    always_comb begin
        case (size)
            ACC_BYTE: misaligned = 1'b0;
            ACC_HALF: misaligned = off[0];
            ACC_WORD: misaligned = |off;
            default:  misaligned = 1'b1;
        endcase
    end
endmodule

// File: rtl/lane_store_pack.sv
module lane_store_pack
    import lane_unit_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  acc_size_e           size,
    input  logic [1:0]          off,
    input  logic                big,
    input  logic [DATA_W-1:0]   value,
    output logic [DATA_W/8-1:0] be,
    output logic [DATA_W-1:0]   lanes
);
    localparam int LANES = DATA_W / 8;

    int nb;

    always_comb begin
        be    = '0;
        lanes = '0;
        nb    = size_bytes(size);
        for (int l = 0; l < LANES; l++) begin
            int j;
            j = l - int'(off);
            if (j >= 0 && j < nb) begin
                be[l] = 1'b1;
                if (big)
                    lanes[8*l +: 8] = value[8*(nb-1-j) +: 8];
                else
                    lanes[8*l +: 8] = value[8*j +: 8];
            end
        end
    end
endmodule

// File: rtl/lane_load_unpack.sv
module lane_load_unpack
    import lane_unit_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  acc_size_e         size,
    input  logic [1:0]        off,
    input  logic              big,
    input  logic              sext,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] value
);
    localparam int LANES = DATA_W / 8;

    int   nb;
    logic sign;

    always_comb begin
        value = '0;
        sign  = 1'b0;
        nb    = size_bytes(size);
        for (int k = 0; k < LANES; k++) begin
            int src;
            src = big ? (int'(off) + nb - 1 - k) : (int'(off) + k);
            if (k < nb && src >= 0 && src < LANES)
                value[8*k +: 8] = rdata[8*src +: 8];
        end
        if (sext && nb > 0 && nb < LANES) begin
            sign = value[8*nb-1];
            for (int b = 0; b < DATA_W; b++) begin
                if (b >= 8*nb)
                    value[b] = sign;
            end
        end
    end
endmodule

// File: rtl/bi_endian_lane_unit.sv
module bi_endian_lane_unit
    import lane_unit_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [1:0]          req_size,
    input  logic                req_sext,
    input  logic                big_endian,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                load_valid,
    output logic [DATA_W-1:0]   load_data,
    output logic                fault
);
    localparam int LANES = DATA_W / 8;

    acc_size_e         size_in;
    logic [1:0]        off_in;
    logic              misaligned;
    logic              go;
    logic [LANES-1:0]  be_in;
    logic [DATA_W-1:0] lanes_in;
    load_ctx_t         ctx;
    logic [DATA_W-1:0] unpacked;

    assign size_in = acc_size_e'(req_size);
    assign off_in  = req_addr[1:0];
    assign go      = req_valid && !misaligned;

    lane_align_check u_align (
        .size       (size_in),
        .off        (off_in),
        .misaligned (misaligned)
    );

    lane_store_pack #(.DATA_W(DATA_W)) u_pack (
        .size  (size_in),
        .off   (off_in),
        .big   (big_endian),
        .value (req_wdata),
        .be    (be_in),
        .lanes (lanes_in)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_be    <= '0;
            mem_wdata <= '0;
            fault     <= 1'b0;
            ctx       <= '0;
        end else begin
            mem_req   <= go;
            mem_we    <= go && req_write;
            mem_addr  <= {req_addr[ADDR_W-1:2], 2'b00};
            mem_be    <= go ? be_in : '0;
            mem_wdata <= (go && req_write) ? lanes_in : '0;
            fault     <= req_valid && misaligned;
            ctx.size  <= size_in;
            ctx.off   <= off_in;
            ctx.sext  <= req_sext;
            ctx.big   <= big_endian;
            ctx.live  <= go && !req_write;
        end
    end

    lane_load_unpack #(.DATA_W(DATA_W)) u_unpack (
        .size  (ctx.size),
        .off   (ctx.off),
        .big   (ctx.big),
        .sext  (ctx.sext),
        .rdata (mem_rdata),
        .value (unpacked)
    );

    assign load_valid = ctx.live;
    assign load_data  = ctx.live ? unpacked : '0;

endmodule

// File: rtl/lane_unit_checker.sv
module lane_unit_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic [1:0]          req_size,
    input logic [ADDR_W-1:0]   req_addr,
    input logic                mem_req,
    input logic                mem_we,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [DATA_W/8-1:0] mem_be,
    input logic                load_valid,
    input logic [DATA_W-1:0]   load_data,
    input logic                fault
);
    a_r8_fault_blocks_memory: assert property (@(posedge clk) disable iff (rst)
        fault |-> (!mem_req && !mem_we && mem_be == '0));

    a_r8_odd_half_faults: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == 2'b01 && req_addr[0]) |=> fault);

    a_r8_bad_size_faults: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == 2'b11) |=> fault);

    a_r10_one_response: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (mem_req != fault));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!mem_req && !fault && !load_valid));

    a_r4_lane_count: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                     $countones(mem_be) == 4));

    a_r4_word_address: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    a_r9_zero_when_invalid: assert property (@(posedge clk) disable iff (rst)
        !load_valid |-> (load_data == '0));

    a_r9_no_load_on_fault: assert property (@(posedge clk) disable iff (rst)
        fault |-> !load_valid);
endmodule

bind bi_endian_lane_unit lane_unit_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_size   (req_size),
    .req_addr   (req_addr),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be),
    .load_valid (load_valid),
    .load_data  (load_data),
    .fault      (fault)
);

// File: tb/bi_endian_lane_unit_tb.sv
module bi_endian_lane_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_sext, big_endian;
    logic [1:0]  req_size;
    logic [31:0] req_addr, req_wdata;
    logic        mem_req, mem_we, load_valid, fault;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, load_data;
    logic [3:0]  mem_be;

    logic [7:0]  mem     [16];
    logic [7:0]  mem_exp [16];
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    bi_endian_lane_unit u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_sext(req_sext), .big_endian(big_endian),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .load_valid(load_valid),
        .load_data(load_data), .fault(fault)
    );

    // memory model: lane i is byte mem_addr+i
    always_comb begin
        for (int i = 0; i < 4; i++)
            mem_rdata[8*i +: 8] = mem[{mem_addr[3:2], 2'(i)}];
    end

    always @(negedge clk) begin
        if (mem_we)
            for (int i = 0; i < 4; i++)
                if (mem_be[i]) mem[{mem_addr[3:2], 2'(i)}] <= mem_wdata[8*i +: 8];
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(posedge clk); #2;
    endtask

    task automatic issue(logic wr, logic [1:0] sz, logic sx, logic big,
                         logic [31:0] a, logic [31:0] d);
        req_write = wr; req_size = sz; req_sext = sx; big_endian = big;
        req_addr = a; req_wdata = d; req_valid = 1'b1;
        @(posedge clk); #2;
        req_valid = 1'b0;
    endtask

    function automatic logic [3:0] exp_mask(logic [1:0] sz, logic [1:0] off);
        logic [3:0] m;
        m = (sz == 2'b00) ? 4'b0001 : (sz == 2'b01) ? 4'b0011 : 4'b1111;
        return m << off;
    endfunction

    function automatic logic [31:0] exp_load(logic big, logic [1:0] sz, logic sx,
                                             logic [3:0] a);
        logic [31:0] v;
        case (sz)
            2'b00: v = {24'h0, mem[a]};
            2'b01: v = big ? {16'h0, mem[a], mem[a+1]} : {16'h0, mem[a+1], mem[a]};
            default: v = big ? {mem[a], mem[a+1], mem[a+2], mem[a+3]}
                             : {mem[a+3], mem[a+2], mem[a+1], mem[a]};
        endcase
        if (sx && sz == 2'b00) v = {{24{v[7]}}, v[7:0]};
        if (sx && sz == 2'b01) v = {{16{v[15]}}, v[15:0]};
        return v;
    endfunction

    task automatic mem_compare(string tag);
        int bad = 0;
        for (int i = 0; i < 16; i++) if (mem[i] !== mem_exp[i]) bad++;
        check(tag, 32'(bad), 32'd0);
    endtask

    // store scenario: expected bytes follow the byte-order rule of R2/R3
    task automatic do_store(string tag, logic big, logic [1:0] sz, logic [31:0] a,
                            logic [31:0] d);
        int nb = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        for (int j = 0; j < nb; j++)
            mem_exp[a[3:0] + 4'(j)] = big ? d[8*(nb-1-j) +: 8] : d[8*j +: 8];
        issue(1'b1, sz, 1'b0, big, a, d);
        check({tag, " R4 be"}, {28'h0, mem_be}, {28'h0, exp_mask(sz, a[1:0])});
        check({tag, " R4 addr"}, mem_addr, {a[31:2], 2'b00});
        check({tag, " R10 we"}, {30'h0, mem_we, fault}, 32'h2);
        idle();
        mem_compare({tag, " memory"});
    endtask

    task automatic do_load(string tag, logic big, logic [1:0] sz, logic sx,
                           logic [31:0] a, logic [31:0] lit);
        logic [31:0] e;
        e = exp_load(big, sz, sx, a[3:0]);
        check({tag, " model"}, e, lit);
        issue(1'b0, sz, sx, big, a, 32'h0);
        check({tag, " R10 valid"}, {30'h0, load_valid, mem_req}, 32'h3);
        check({tag, " R4 be"}, {28'h0, mem_be}, {28'h0, exp_mask(sz, a[1:0])});
        check(tag, load_data, e);
        idle();
    endtask

    task automatic do_bad(string tag, logic wr, logic [1:0] sz, logic [31:0] a);
        issue(wr, sz, 1'b1, 1'b1, a, 32'hFFFF_FFFF);
        check({tag, " R8 fault"}, {31'h0, fault}, 32'h1);
        check({tag, " R8 quiet"}, {28'h0, mem_be} | {30'h0, mem_req, mem_we}, 32'h0);
        check({tag, " R9 load"}, load_data | {31'h0, load_valid}, 32'h0);
        idle();
        check({tag, " R8 one cycle"}, {31'h0, fault}, 32'h0);
        mem_compare({tag, " R8 memory kept"});
    endtask

    task automatic test_reset();
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_size = 2'b00;
        req_sext = 1'b0; big_endian = 1'b0; req_addr = '0; req_wdata = '0;
        for (int i = 0; i < 16; i++) begin mem[i] = 8'h00; mem_exp[i] = 8'h00; end
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset outs", mem_addr | mem_wdata | load_data |
              {25'h0, mem_be, mem_req, mem_we, fault}, 32'h0);
        rst = 1'b0;
        idle();
        check("R1 after reset", {29'h0, mem_req, fault, load_valid}, 32'h0);
    endtask

    task automatic test_word_orders();
        do_store("R2 word big", 1'b1, 2'b10, 32'h0000_1000, 32'hAABBCCDD);
        check("R2 bytes", {mem[0], mem[1], mem[2], mem[3]}, 32'hAABBCCDD);
        do_store("R3 word little", 1'b0, 2'b10, 32'h0000_1004, 32'hAABBCCDD);
        check("R3 bytes", {mem[4], mem[5], mem[6], mem[7]}, 32'hDDCCBBAA);
    endtask

    task automatic test_lane_data();
        issue(1'b1, 2'b10, 1'b0, 1'b1, 32'h0000_1000, 32'hAABBCCDD);
        check("R2 R4 lanes big", mem_wdata, 32'hDDCCBBAA);
        idle();
        issue(1'b1, 2'b01, 1'b0, 1'b1, 32'h0000_100A, 32'h0000_1234);
        check("R2 R4 lanes half", mem_wdata & 32'hFFFF_0000, 32'h3412_0000);
        idle();
        mem[10] = 8'h12; mem[11] = 8'h34; mem_exp[10] = 8'h12; mem_exp[11] = 8'h34;
    endtask

    task automatic test_narrow_stores();
        do_store("R2 half big", 1'b1, 2'b01, 32'h0000_100A, 32'hFFFF_1234);
        check("R2 half bytes", {16'h0, mem[10], mem[11]}, 32'h1234);
        do_store("R3 half little", 1'b0, 2'b01, 32'h0000_1008, 32'h0000_7F80);
        check("R3 half bytes", {16'h0, mem[8], mem[9]}, 32'h807F);
        do_store("R4 byte lane3", 1'b1, 2'b00, 32'h0000_100F, 32'h1234_565A);
        check("R4 byte", {24'h0, mem[15]}, 32'h5A);
        do_store("R4 byte lane1", 1'b0, 2'b00, 32'h0000_100D, 32'h0000_00C3);
    endtask

    task automatic test_loads();
        do_load("R5 word big", 1'b1, 2'b10, 1'b0, 32'h0000_1000, 32'hAABBCCDD);
        do_load("R6 word little", 1'b0, 2'b10, 1'b1, 32'h0000_1000, 32'hDDCCBBAA);
        do_load("R6 R7 half little signed", 1'b0, 2'b01, 1'b1, 32'h0000_1004, 32'hFFFFCCDD);
        do_load("R6 R7 half little zero", 1'b0, 2'b01, 1'b0, 32'h0000_1004, 32'h0000CCDD);
        do_load("R5 R7 half big signed", 1'b1, 2'b01, 1'b1, 32'h0000_1002, 32'hFFFFCCDD);
        do_load("R7 byte signed", 1'b1, 2'b00, 1'b1, 32'h0000_1001, 32'hFFFFFFBB);
        do_load("R7 byte zero", 1'b0, 2'b00, 1'b0, 32'h0000_1007, 32'h000000AA);
        do_load("R7 half positive", 1'b0, 2'b01, 1'b1, 32'h0000_1008, 32'h00007F80);
        do_load("R5 half big lane2", 1'b1, 2'b01, 1'b0, 32'h0000_100A, 32'h00001234);
    endtask

    task automatic test_faults();
        do_bad("R8 half odd store", 1'b1, 2'b01, 32'h0000_1001);
        do_bad("R8 word off2 load", 1'b0, 2'b10, 32'h0000_1002);
        do_bad("R8 word off1 store", 1'b1, 2'b10, 32'h0000_1005);
        do_bad("R8 bad size", 1'b1, 2'b11, 32'h0000_1000);
        do_bad("R9 half odd load", 1'b0, 2'b01, 32'h0000_1003);
    endtask

    initial begin
        test_reset();
        test_word_orders();
        test_lane_data();
        test_narrow_stores();
        test_loads();
        test_faults();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule